// File: doc/BRIEF.md
# Jump-Controlled 18-Cell Register

An 18-bit linear finite state machine built from cells that can play one of two roles. A shift cell takes on the value of the cell below it. A feedback cell takes that same value and also XORs in its own current contents. A single jump-control bit flips the role of every cell at once. One clock therefore moves the machine either one state forward or a fixed, large number of states forward. The XOR count is the same in both cases, so the work done per clock does not depend on the control bit.

Cell 1 is fed by the XOR of the tap cells, and cell 18 is always one of the taps. A parameter selects one of two tap and role configurations, and each configuration has a different jump distance. An initialization mode runs the register with the roles fixed as if jump control were 0, and XORs an injection bit into the feedback entering cell 1. A parallel load sets the whole state. The full state and one key-stream tap bit are outputs. The nonlinear filter that produces the jump-control and injection bits, and the sequencing of the register, sit outside this block.

Top module: `jump_cell_reg`

## Requirements
- R1: A synchronous active-high reset sets the state to RESET_STATE (default 18'h00001). Bit k-1 of `state` holds cell k.
- R2: When `loadEn` is 1, the next state equals `loadValue`, whatever the other inputs are.
- R3: When `loadEn` and `stepEn` are both 0, the state does not change. `jumpCtl`, `initMode` and `injectIn` then have no effect.
- R4: With `stepEn`=1, `jumpCtl`=0 and `initMode`=0, cell k (k=2..18) becomes cell k-1, XORed with its own value if cell k is a feedback cell. Cell 1 becomes the XOR of the tap cells, XORed with its own value if cell 1 is a feedback cell. In configuration 1 the taps are cells 3, 8, 16 and 18, and the feedback cells are 3, 9, 10, 11, 12, 14, 15, 16 and 18.
- R5: With `jumpCtl`=1, every cell takes the opposite role. The next state then equals the R4 next state XORed with the current state (transition matrix plus identity).
- R6: One jump step gives the same state as 84074 plain steps in configuration 1, and as 27044 plain steps in configuration 2.
- R7: With `initMode`=1 and `stepEn`=1, `jumpCtl` is ignored and the roles are those of R4. `injectIn` is XORed into the value entering cell 1.
- R8: `keyTap` equals cell 17, that is `state[16]`.
- R9: With `initMode`=0, `injectIn` has no effect on the next state.
- R10: Configuration 2 has taps at cells 6, 8, 14 and 18, and feedback cells (at `jumpCtl`=0) at 3, 7, 9, 10, 11, 12, 13, 14 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Parallel load strobe; has priority over stepping |
| loadValue | input | 18 | Value to load; bit k-1 is cell k |
| stepEn | input | 1 | Advance the register by one transition |
| jumpCtl | input | 1 | 1 inverts every cell role for this step |
| initMode | input | 1 | Forces the roles of jump control 0 and enables injection |
| injectIn | input | 1 | Bit XORed into the feedback entering cell 1 in init mode |
| state | output | 18 | Full register state |
| keyTap | output | 1 | Key-stream contribution bit (cell 17) |

## Verification
The non-zero check assumes that the state is never zero before a step. This holds because reset and every load in the stimulus give a non-zero value, and a step with no injection is a bijection. The init-mode steps that inject a bit start from non-zero states. The hold and load checks assume that the control inputs change only between clock edges. The bench drives them on the falling edge.

// File: rtl/jcreg_pkg.sv
package jcreg_pkg;

  localparam int CellCount = 18;

  typedef logic [CellCount-1:0] cellVec_t;

  typedef struct packed {
    logic doLoad;
    logic doStep;
    logic invertRoles;
    logic injectBit;
  } regStrobe_t;

  // Role mask at jump control 0: bit k-1 set means cell k is a feedback cell.
  function automatic cellVec_t roleMask(input int cfg);
    if (cfg == 2) return 18'h0BF44;
    return 18'h2EF04;
  endfunction

  // Cells whose contents are summed into the value entering cell 1.
  function automatic cellVec_t tapMask(input int cfg);
    if (cfg == 2) return 18'h220A0;
    return 18'h28084;
  endfunction

endpackage

// File: rtl/jcreg_ctrl.sv
module jcreg_ctrl
  import jcreg_pkg::*;
(
  input  logic       loadEn,
  input  logic       stepEn,
  input  logic       jumpCtl,
  input  logic       initMode,
  input  logic       injectIn,
  output regStrobe_t strobe
);

  always_comb begin
    strobe.doLoad      = loadEn;
    strobe.doStep      = stepEn && !loadEn;
    strobe.invertRoles = jumpCtl && !initMode;
    strobe.injectBit   = injectIn && initMode;
  end

endmodule

// File: rtl/jcreg_path.sv
module jcreg_path
  import jcreg_pkg::*;
#(
  parameter int       CONFIG      = 1,
  parameter cellVec_t RESET_STATE = 18'h00001
) (
  input  logic       clk,
  input  logic       rst,
  input  regStrobe_t strobe,
  input  cellVec_t   loadValue,
  output cellVec_t   state,
  output logic       keyTap
);

  localparam cellVec_t RoleBase = roleMask(CONFIG);
  localparam cellVec_t TapSel   = tapMask(CONFIG);
  localparam int       TapCell  = 16;

  cellVec_t nextState;
  cellVec_t selfTerm;
  logic     loopFeed;

  assign loopFeed = (^(state & TapSel)) ^ strobe.injectBit;

  for (genvar k = 0; k < CellCount; k++) begin : g_cell
    assign selfTerm[k] = (RoleBase[k] ^ strobe.invertRoles) & state[k];
    if (k == 0) begin : g_head
      assign nextState[k] = loopFeed ^ selfTerm[k];
    end else begin : g_body
      assign nextState[k] = state[k-1] ^ selfTerm[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                state <= RESET_STATE;
    else if (strobe.doLoad) state <= loadValue;
    else if (strobe.doStep) state <= nextState;
  end

  assign keyTap = state[TapCell];

  // R2
  load_prio_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.doLoad |=> state == $past(loadValue));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.doLoad && !strobe.doStep) |=> $stable(state));

  // R5
  nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.doLoad && strobe.doStep && !strobe.injectBit && state != '0)
      |=> state != '0);

  // R8
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.doLoad && !strobe.doStep) |=> $stable(keyTap));

endmodule

// File: rtl/jump_cell_reg.sv
module jump_cell_reg
  import jcreg_pkg::*;
#(
  parameter int       CONFIG      = 1,
  parameter cellVec_t RESET_STATE = 18'h00001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        loadEn,
  input  logic [17:0] loadValue,
  input  logic        stepEn,
  input  logic        jumpCtl,
  input  logic        initMode,
  input  logic        injectIn,
  output logic [17:0] state,
  output logic        keyTap
);

  regStrobe_t strobe;

  jcreg_ctrl u_ctrl (
    .loadEn   (loadEn),
    .stepEn   (stepEn),
    .jumpCtl  (jumpCtl),
    .initMode (initMode),
    .injectIn (injectIn),
    .strobe   (strobe)
  );

  jcreg_path #(
    .CONFIG      (CONFIG),
    .RESET_STATE (RESET_STATE)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .loadValue (loadValue),
    .state     (state),
    .keyTap    (keyTap)
  );

endmodule

// File: tb/jump_cell_reg_test.sv
module jump_cell_reg_test;

  logic        clk = 0;
  logic        rst = 1;
  logic        loadEn = 0;
  logic [17:0] loadValue = '0;
  logic        stepEn = 0;
  logic        jumpCtl = 0;
  logic        initMode = 0;
  logic        injectIn = 0;
  logic [17:0] stateA, stateB;
  logic        tapA, tapB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  jump_cell_reg #(.CONFIG(1)) uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadValue(loadValue),
    .stepEn(stepEn), .jumpCtl(jumpCtl), .initMode(initMode),
    .injectIn(injectIn), .state(stateA), .keyTap(tapA));

  jump_cell_reg #(.CONFIG(2)) uut2 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadValue(loadValue),
    .stepEn(stepEn), .jumpCtl(jumpCtl), .initMode(initMode),
    .injectIn(injectIn), .state(stateB), .keyTap(tapB));

  // Plain-step model written from the role lists in R4 and R10.
  function automatic logic [17:0] plainStep(input int cfg, input logic [17:0] s,
                                            input logic inj);
    int fb1[9] = '{3, 9, 10, 11, 12, 14, 15, 16, 18};
    int fb2[9] = '{3, 7, 9, 10, 11, 12, 13, 14, 16};
    int tp1[4] = '{3, 8, 16, 18};
    int tp2[4] = '{6, 8, 14, 18};
    logic [18:1] c, n;
    logic [18:1] isFb;
    logic head;
    c = s;
    isFb = '0;
    for (int i = 0; i < 9; i++) isFb[cfg == 2 ? fb2[i] : fb1[i]] = 1'b1;
    head = inj;
    for (int i = 0; i < 4; i++) head ^= c[cfg == 2 ? tp2[i] : tp1[i]];
    n[1] = head ^ (isFb[1] & c[1]);
    for (int k = 2; k <= 18; k++) n[k] = c[k-1] ^ (isFb[k] & c[k]);
    return n;
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic [17:0] val, input logic st,
                       input logic jc, input logic im, input logic inj);
    loadEn = ld; loadValue = val; stepEn = st;
    jumpCtl = jc; initMode = im; injectIn = inj;
    @(posedge clk); @(negedge clk);
    loadEn = 0; stepEn = 0; jumpCtl = 0; initMode = 0; injectIn = 0;
  endtask

  task automatic loadBoth(input logic [17:0] v);
    cycle(1, v, 0, 0, 0, 0);
  endtask

  task automatic testReset;
    check("R1 cfg1", stateA, 18'h00001);
    check("R1 cfg2", stateB, 18'h00001);
    check("R8 reset tap", {17'b0, tapA}, 18'h0);
  endtask

  task automatic testLoadPriority;
    cycle(1, 18'h2B3C1, 1, 1, 1, 1);
    check("R2 cfg1", stateA, 18'h2B3C1);
    check("R2 cfg2", stateB, 18'h2B3C1);
  endtask

  task automatic testHold;
    cycle(0, 18'h3FFFF, 0, 1, 1, 1);
    check("R3 cfg1", stateA, 18'h2B3C1);
    check("R3 cfg2", stateB, 18'h2B3C1);
  endtask

  task automatic testPlain;
    logic [17:0] ea, eb;
    loadBoth(18'h1F00D);
    ea = 18'h1F00D; eb = 18'h1F00D;
    for (int i = 0; i < 24; i++) begin
      cycle(0, 0, 1, 0, 0, 0);
      ea = plainStep(1, ea, 1'b0);
      eb = plainStep(2, eb, 1'b0);
      check("R4", stateA, ea);
      check("R10", stateB, eb);
      check("R8", {17'b0, tapA}, {17'b0, ea[16]});
    end
  endtask

  task automatic testJump;
    logic [17:0] s;
    s = 18'h30A5A;
    loadBoth(s);
    for (int i = 0; i < 6; i++) begin
      cycle(0, 0, 1, 1, 0, 0);
      check("R5 cfg1", stateA, plainStep(1, s, 1'b0) ^ s);
      s = stateA;
    end
    s = 18'h0C3E7;
    loadBoth(s);
    cycle(0, 0, 1, 1, 0, 0);
    check("R5 cfg2", stateB, plainStep(2, s, 1'b0) ^ s);
  endtask

  task automatic testInit;
    logic [17:0] s;
    s = 18'h12345;
    loadBoth(s);
    cycle(0, 0, 1, 1, 1, 1);
    check("R7 cfg1", stateA, plainStep(1, s, 1'b1));
    check("R7 cfg2", stateB, plainStep(2, s, 1'b1));
    s = stateA;
    cycle(0, 0, 1, 1, 1, 0);
    check("R7 no inject", stateA, plainStep(1, s, 1'b0));
    s = stateA;
    cycle(0, 0, 1, 0, 0, 1);
    check("R9", stateA, plainStep(1, s, 1'b0));
  endtask

  task automatic testJumpDistance;
    logic [17:0] seed, jA, jB;
    seed = 18'h1A5C3;
    loadBoth(seed);
    cycle(0, 0, 1, 1, 0, 0);
    jA = stateA; jB = stateB;
    loadBoth(seed);
    stepEn = 1;
    repeat (27044) @(posedge clk);
    @(negedge clk);
    check("R6 cfg2", stateB, jB);
    repeat (84074 - 27044) @(posedge clk);
    @(negedge clk);
    stepEn = 0;
    check("R6 cfg1", stateA, jA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    testReset();
    testLoadPriority();
    testHold();
    testPlain();
    testJump();
    testInit();
    testJumpDistance();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule